// File: doc/BRIEF.md
# Multi-Window Bus Slave Decoder

This block sits on the address phase of a processor bus. When a transfer starts, it compares the bus address and the transfer-type code against a set of programmed address windows. It then decides whether one of them claims the address tenure. Each window is placed by a base address and sized by a power-of-two exponent. Each window holds a bitmask of the transfer-type codes it accepts, and each window has an enable bit.

There are eight general-purpose windows. Each one carries memory or I/O traffic to one of two downstream PCI ports, chosen by a per-window port bit. Five specialty windows follow them, at fixed indices with a fixed purpose and port:

- configuration cycles toward port 0 and toward port 1;
- interrupt-acknowledge reads toward port 0 and toward port 1;
- accesses to the device's own registers.

The claim decision, the winning window index and its route are all registered one cycle after the transfer-start strobe.

A master-based decode mode input lets the block ignore transfers that the device's own bus master started. With the mode off, those transfers are decoded like any other.

Top module: `bus_window_decoder`

## Requirements
- R1: Window w matches address A when A and the window base agree in every bit at or above position E, where E is the window's size exponent (window size 2^E bytes). Bits below E are ignored, and bases are aligned to their size.
- R2: A window only claims when bit T of its 32-bit type mask is set, where T is the 5-bit transfer-type code of the transfer.
- R3: A window whose enable bit is 0 never claims, whatever the address and type. Setting the enable bit makes the same transfer claim.
- R4: When several windows qualify, the lowest-numbered one wins.
- R5: claim_o is high in the cycle after the clock edge that sampled start_i high with a qualifying window. In that cycle, claim_idx_o gives the winning index and claim_onehot_o has exactly bit claim_idx_o set.
- R6: Windows 0 to 7 report kind 0 (memory/I/O) and take their port from win_port_i. The specialty windows are fixed, kind codes in brackets:
  - window 8: configuration (1), port 0;
  - window 9: configuration (1), port 1;
  - window 10: interrupt-acknowledge (2), port 0;
  - window 11: interrupt-acknowledge (2), port 1;
  - window 12: register access (3), port 0.
- R7: claim_o is low in any cycle not directly following a clock edge where start_i was high.
- R8: With master_decode_i = 0, a transfer flagged own_master_i = 1 is claimed normally. With master_decode_i = 1, such a transfer is never claimed.
- R9: After reset, claim_o, claim_idx_o, claim_onehot_o, claim_port_o and claim_kind_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer-start strobe, one cycle per address phase |
| addr_i | input | AW | Bus address of the transfer |
| ttype_i | input | TTW | Transfer-type code |
| own_master_i | input | 1 | Transfer was started by the device's own bus master |
| master_decode_i | input | 1 | Master-based decode mode select |
| win_en_i | input | NGEN+5 | Per-window enable |
| win_base_i | input | (NGEN+5)×AW | Per-window base address |
| win_exp_i | input | (NGEN+5)×SW | Per-window size exponent |
| win_tmask_i | input | (NGEN+5)×2^TTW | Per-window accepted transfer-type mask |
| win_port_i | input | NGEN | Destination port of each general window |
| claim_o | output | 1 | Claim strobe |
| claim_idx_o | output | IDXW | Encoded winning window |
| claim_onehot_o | output | NGEN+5 | One-hot winning window |
| claim_port_o | output | 1 | Destination port of the winner |
| claim_kind_o | output | 2 | Access kind of the winner |

## Verification
The assertions take three things for granted about the inputs:
- start_i is a clean strobe, so the transfer in flight is the one sampled on the edge before a claim;
- the window configuration is steady whenever start_i is high;
- every base is aligned to its window size.

The bench writes the whole window setup while start_i is low, and uses only aligned bases. It drives each transfer for exactly one cycle on the falling edge, then checks the claim and its route on the following falling edge. One cycle later it checks that the strobe has dropped.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  localparam int unsigned NSPEC = 5;

  typedef enum logic [1:0] {
    WK_MEMIO = 2'd0,
    WK_CFG   = 2'd1,
    WK_IACK  = 2'd2,
    WK_REG   = 2'd3
  } win_kind_e;

  // Specialty slot s: 0 cfg p0, 1 cfg p1, 2 iack p0, 3 iack p1, 4 registers
  function automatic win_kind_e spec_kind(input int unsigned s);
    case (s)
      0, 1:    spec_kind = WK_CFG;
      2, 3:    spec_kind = WK_IACK;
      default: spec_kind = WK_REG;
    endcase
  endfunction

  function automatic logic spec_port(input int unsigned s);
    spec_port = (s == 1) || (s == 3);
  endfunction

endpackage

// File: rtl/bwd_window_match.sv
module bwd_window_match #(
  parameter int unsigned AW  = 32,
  parameter int unsigned SW  = 5,
  parameter int unsigned TTW = 5,
  localparam int unsigned TTN = 1 << TTW
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [TTW-1:0] ttype_i,
  input  logic           en_i,
  input  logic [AW-1:0]  base_i,
  input  logic [SW-1:0]  exp_i,
  input  logic [TTN-1:0] tmask_i,
  output logic           hit_o
);

  logic [AW-1:0] upper_mask;
  logic          addr_ok;
  logic          type_ok;

  always_comb begin
    upper_mask = {AW{1'b1}} << exp_i;
    addr_ok    = ((addr_i ^ base_i) & upper_mask) == '0;
    type_ok    = tmask_i[ttype_i];
    hit_o      = en_i && addr_ok && type_ok;
  end

endmodule

// File: rtl/bwd_lowest_pick.sv
module bwd_lowest_pick #(
  parameter int unsigned N = 13,
  localparam int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o,
  output logic [N-1:0]    onehot_o
);

  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o    = 1'b1;
        idx_o    = IDXW'(i);
        onehot_o = '0;
        onehot_o[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bus_window_decoder.sv
module bus_window_decoder
  import bwd_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned TTW  = 5,
  parameter int unsigned SW   = 5,
  parameter int unsigned NGEN = 8,
  localparam int unsigned NWIN = NGEN + NSPEC,
  localparam int unsigned TTN  = 1 << TTW,
  localparam int unsigned IDXW = $clog2(NWIN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [TTW-1:0]            ttype_i,
  input  logic                      own_master_i,
  input  logic                      master_decode_i,
  input  logic [NWIN-1:0]           win_en_i,
  input  logic [NWIN-1:0][AW-1:0]   win_base_i,
  input  logic [NWIN-1:0][SW-1:0]   win_exp_i,
  input  logic [NWIN-1:0][TTN-1:0]  win_tmask_i,
  input  logic [NGEN-1:0]           win_port_i,
  output logic                      claim_o,
  output logic [IDXW-1:0]           claim_idx_o,
  output logic [NWIN-1:0]           claim_onehot_o,
  output logic                      claim_port_o,
  output logic [1:0]                claim_kind_o
);

  logic [NWIN-1:0]       hit;
  logic [NWIN-1:0]       port_tab;
  logic [NWIN-1:0][1:0]  kind_tab;
  logic                  pick_any;
  logic [IDXW-1:0]       pick_idx;
  logic [NWIN-1:0]       pick_onehot;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    bwd_window_match #(.AW(AW), .SW(SW), .TTW(TTW)) i_match (
      .addr_i  (addr_i),
      .ttype_i (ttype_i),
      .en_i    (win_en_i[w]),
      .base_i  (win_base_i[w]),
      .exp_i   (win_exp_i[w]),
      .tmask_i (win_tmask_i[w]),
      .hit_o   (hit[w])
    );
    if (w < NGEN) begin : g_gen
      assign port_tab[w] = win_port_i[w];
      assign kind_tab[w] = WK_MEMIO;
    end else begin : g_spec
      assign port_tab[w] = spec_port(w - NGEN);
      assign kind_tab[w] = spec_kind(w - NGEN);
    end
  end

  bwd_lowest_pick #(.N(NWIN)) i_pick (
    .req_i    (hit),
    .any_o    (pick_any),
    .idx_o    (pick_idx),
    .onehot_o (pick_onehot)
  );

  // next-state
  logic            claim_d;
  logic [IDXW-1:0] idx_d;
  logic [NWIN-1:0] onehot_d;
  logic            port_d;
  logic [1:0]      kind_d;
  logic            blocked;

  always_comb begin
    blocked  = master_decode_i && own_master_i;
    claim_d  = start_i && pick_any && !blocked;
    idx_d    = '0;
    onehot_d = '0;
    port_d   = 1'b0;
    kind_d   = '0;
    if (claim_d) begin
      idx_d    = pick_idx;
      onehot_d = pick_onehot;
      port_d   = port_tab[pick_idx];
      kind_d   = kind_tab[pick_idx];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_o <= 1'b0;
    end else begin
      claim_o <= claim_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_idx_o    <= '0;
      claim_onehot_o <= '0;
      claim_port_o   <= 1'b0;
      claim_kind_o   <= '0;
    end else if (start_i) begin
      claim_idx_o    <= idx_d;
      claim_onehot_o <= onehot_d;
      claim_port_o   <= port_d;
      claim_kind_o   <= kind_d;
    end
  end

  // assertions
  a_r5_onehot_single: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> $countones(claim_onehot_o) == 1);

  a_r5_onehot_matches_idx: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> claim_onehot_o[claim_idx_o]);

  a_r7_claim_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !claim_o);

  a_r8_master_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (master_decode_i && own_master_i) |=> !claim_o);

  a_r6_general_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_o && claim_idx_o < IDXW'(NGEN)) |-> claim_kind_o == 2'(WK_MEMIO));

  a_r3_enabled_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !blocked && pick_any) |-> win_en_i[pick_idx]);

endmodule

// File: tb/test_bus_window_decoder.sv
module test_bus_window_decoder;

  localparam int NWIN = 13;

  logic                     clk;
  logic                     rst_n;
  logic                     start_i;
  logic [31:0]              addr_i;
  logic [4:0]               ttype_i;
  logic                     own_master_i;
  logic                     master_decode_i;
  logic [NWIN-1:0]          win_en_i;
  logic [NWIN-1:0][31:0]    win_base_i;
  logic [NWIN-1:0][4:0]     win_exp_i;
  logic [NWIN-1:0][31:0]    win_tmask_i;
  logic [7:0]               win_port_i;
  logic                     claim_o;
  logic [3:0]               claim_idx_o;
  logic [NWIN-1:0]          claim_onehot_o;
  logic                     claim_port_o;
  logic [1:0]               claim_kind_o;

  int checks = 0;
  int errors = 0;

  bus_window_decoder i_bus_window_decoder (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .ttype_i(ttype_i), .own_master_i(own_master_i),
    .master_decode_i(master_decode_i), .win_en_i(win_en_i),
    .win_base_i(win_base_i), .win_exp_i(win_exp_i),
    .win_tmask_i(win_tmask_i), .win_port_i(win_port_i),
    .claim_o(claim_o), .claim_idx_o(claim_idx_o),
    .claim_onehot_o(claim_onehot_o), .claim_port_o(claim_port_o),
    .claim_kind_o(claim_kind_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one transfer, check the claim cycle, then check the strobe drops
  task automatic xfer(input string req, input logic [31:0] a, input logic [4:0] tt, input logic own,
                      input logic exp_claim, input int exp_idx, input logic exp_port, input int exp_kind);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; ttype_i = tt; own_master_i = own;
    @(negedge clk);
    start_i = 1'b0; own_master_i = 1'b0;
    chk(req, 32'(claim_o), 32'(exp_claim), "claim");
    if (exp_claim) begin
      chk(req, 32'(claim_idx_o), 32'(exp_idx), "index");
      chk("R5", 32'(claim_onehot_o), 32'(1) << exp_idx, "onehot");
      chk(req, 32'(claim_port_o), 32'(exp_port), "port");
      chk(req, 32'(claim_kind_o), 32'(exp_kind), "kind");
    end
    @(negedge clk);
    chk("R7", 32'(claim_o), 32'd0, "claim after start low");
  endtask

  task automatic t_reset;
    chk("R9", 32'(claim_o), 0, "reset claim");
    chk("R9", 32'(claim_idx_o), 0, "reset index");
    chk("R9", 32'(claim_onehot_o), 0, "reset onehot");
    chk("R9", 32'(claim_port_o), 0, "reset port");
    chk("R9", 32'(claim_kind_o), 0, "reset kind");
  endtask

  task automatic t_address;
    xfer("R1", 32'h1000_0010, 5'd2, 1'b0, 1'b1, 0, 1'b0, 0);
    xfer("R1", 32'h1080_0000, 5'd2, 1'b0, 1'b1, 1, 1'b1, 0);
    xfer("R1", 32'h10FF_FFFF, 5'd2, 1'b0, 1'b1, 1, 1'b1, 0);
    xfer("R1", 32'h1100_0000, 5'd2, 1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_type_priority;
    xfer("R2", 32'h1000_0010, 5'd10, 1'b0, 1'b1, 1, 1'b1, 0);
    xfer("R4", 32'h100F_FFF0, 5'd2, 1'b0, 1'b1, 0, 1'b0, 0);
    xfer("R2", 32'hF100_0004, 5'd7, 1'b0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_enable;
    xfer("R3", 32'h2000_0100, 5'd2, 1'b0, 1'b0, 0, 1'b0, 0);
    @(negedge clk); win_en_i[2] = 1'b1;
    xfer("R3", 32'h2000_0100, 5'd2, 1'b0, 1'b1, 2, 1'b1, 0);
  endtask

  task automatic t_special;
    xfer("R6", 32'hF000_1234, 5'd2, 1'b0, 1'b1, 8, 1'b0, 1);
    xfer("R6", 32'hF001_0000, 5'd2, 1'b0, 1'b1, 9, 1'b1, 1);
    xfer("R6", 32'hF002_0008, 5'd2, 1'b0, 1'b1, 11, 1'b1, 2);
    xfer("R6", 32'hF100_0FFC, 5'd2, 1'b0, 1'b1, 12, 1'b0, 3);
  endtask

  task automatic t_master;
    master_decode_i = 1'b0;
    xfer("R8", 32'h1000_0010, 5'd2, 1'b1, 1'b1, 0, 1'b0, 0);
    master_decode_i = 1'b1;
    xfer("R8", 32'h1000_0010, 5'd2, 1'b1, 1'b0, 0, 1'b0, 0);
    xfer("R8", 32'h1000_0010, 5'd2, 1'b0, 1'b1, 0, 1'b0, 0);
    master_decode_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; ttype_i = '0;
    own_master_i = 1'b0; master_decode_i = 1'b0;
    win_en_i = '0; win_base_i = '0; win_exp_i = '0; win_tmask_i = '0;
    win_port_i = '0;
    // window 0: 1 MiB at 0x1000_0000, type 2 only, port 0
    win_en_i[0] = 1'b1; win_base_i[0] = 32'h1000_0000; win_exp_i[0] = 5'd20;
    win_tmask_i[0] = 32'h0000_0004;
    // window 1: 16 MiB at 0x1000_0000, all types, port 1
    win_en_i[1] = 1'b1; win_base_i[1] = 32'h1000_0000; win_exp_i[1] = 5'd24;
    win_tmask_i[1] = 32'hFFFF_FFFF; win_port_i[1] = 1'b1;
    // window 2: 4 KiB at 0x2000_0000, disabled at first, port 1
    win_base_i[2] = 32'h2000_0000; win_exp_i[2] = 5'd12;
    win_tmask_i[2] = 32'hFFFF_FFFF; win_port_i[2] = 1'b1;
    // specialty windows
    win_en_i[8] = 1'b1; win_base_i[8] = 32'hF000_0000; win_exp_i[8] = 5'd16;
    win_tmask_i[8] = 32'hFFFF_FFFF;
    win_en_i[9] = 1'b1; win_base_i[9] = 32'hF001_0000; win_exp_i[9] = 5'd16;
    win_tmask_i[9] = 32'hFFFF_FFFF;
    win_en_i[11] = 1'b1; win_base_i[11] = 32'hF002_0000; win_exp_i[11] = 5'd4;
    win_tmask_i[11] = 32'hFFFF_FFFF;
    win_en_i[12] = 1'b1; win_base_i[12] = 32'hF100_0000; win_exp_i[12] = 5'd12;
    win_tmask_i[12] = 32'h0000_0004;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_address();
    t_type_priority();
    t_enable();
    t_special();
    t_master();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule